// File: doc/BRIEF.md
# PCIe Root-Port Link Speed Bring-Up Sequencer

This block brings up a root-port link in a fixed order. On a start request it writes the lowest speed code, 2.5 GT/s, into the controller's supported-speed field. One cycle later it turns on link training and waits a bounded number of cycles for the link to come up. Training always begins at the lowest speed because some downstream switches do not train when a higher speed is offered first.

Once the link is up, and only if the configured maximum generation is two or more, the block advertises 5 GT/s and pulses a request to set the controller's directed speed-change bit. It can then poll that bit until hardware clears it, with a bounded retry count. On variants whose hardware leaves the bit set when no transition takes place, this poll is turned off with an input. The block then waits for link-up a second time before it reports success with the negotiated speed.

Any timeout leads to the failure path. The block pulses two receiver override bits for a PHY, holds them for a fixed number of cycles, clears them, and then reports failure.

Top module: `lsq_link_bringup`

## Requirements
- R1: While reset is active and after it is released, with no start, the outputs are all zero: busy, done, fail, speed-change set, training enable, the override word, the supported-speed field and the reported speed.
- R2: A start request received in idle writes code 4'h1 (2.5 GT/s) into the supported-speed field and clears the training enable. Training enable rises exactly one cycle later, and at that moment the field still holds 4'h1.
- R3: The first link-up wait lasts at most LINK_TIMEOUT cycles, counted from the cycle in which training enable first reads high. Link-up seen in the last of these cycles still counts as success. Link-up never seen leads to the failure path.
- R4: After link-up with a maximum generation input of 2 or 3, the field becomes 4'h2 (5 GT/s), followed by exactly one single-cycle speed-change set pulse. With a maximum generation of 0 or 1, no pulse is issued and the field stays 4'h1.
- R5: With polling enabled, the block samples the speed-change readback once per cycle, for at most POLL_RETRIES cycles after the pulse. If it reads low within that window, the run proceeds. If it stays high through the last cycle, the run takes the failure path.
- R6: With polling disabled, the readback is not consulted, and a bit that stays set does not prevent success.
- R7: After a speed-change request, the block waits again for link-up, with the same LINK_TIMEOUT limit, before it reports success. Losing the link here leads to failure.
- R8: The failure path drives override word 16'h0028 (receiver data-enable override in bit 5, receiver PLL-enable override in bit 3) for exactly HOLD_CYCLES cycles, then returns it to zero. Fail is asserted in the cycle that follows.
- R9: Success gives a one-cycle done pulse, and the reported speed equals link-status bits 3:0 captured on entry to that cycle. Failure gives a one-cycle fail pulse and leaves the reported speed at 0. Done and fail are never high together, and busy is low in the cycle after either one.
- R10: A start request that arrives while busy has no effect: training enable does not drop, and the run ends with a single outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a bring-up run |
| max_gen_i | input | 2 | Highest link generation allowed |
| chg_poll_en_i | input | 1 | Wait for hardware to clear the speed-change bit |
| link_up_i | input | 1 | Link-up flag from the controller |
| spd_chg_pending_i | input | 1 | Readback of the speed-change request bit |
| lnk_sta_speed_i | input | 4 | Current link speed from the link status field |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| cur_speed_o | output | 4 | Negotiated speed captured on success |
| sup_speed_o | output | 4 | Value for the supported-speed field |
| spd_chg_set_o | output | 1 | One-cycle pulse that sets the speed-change bit |
| ltssm_en_o | output | 1 | Link training enable |
| rx_ovrd_o | output | OVRD_W | PHY receiver override word |

## Verification
Two situations are hard to reach from the ports. The first is a readback bit that stays high for exactly POLL_RETRIES-1 or POLL_RETRIES cycles. The second is a link that is up during training but disappears after the speed-change request. The bench contains a small controller model with three delays it can set: cycles until link-up, cycles until the request bit clears (or never), and whether the link drops when the request is issued. Each table row sets these so that a run lands one cycle on either side of a limit. A second start is also injected in the middle of a run.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FORCE,
    ST_TRAIN,
    ST_RAISE,
    ST_REQ,
    ST_POLL,
    ST_RELINK,
    ST_PHYRST,
    ST_DONE,
    ST_FAIL
  } seq_state_e;

  // supported-speed field encodings
  localparam logic [3:0] SPD_2G5 = 4'h1;
  localparam logic [3:0] SPD_5G0 = 4'h2;

  // override bit positions decoded by the PHY
  localparam int RX_DATA_OVRD_BIT = 5;
  localparam int RX_PLL_OVRD_BIT  = 3;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lsq_step_ctr.sv
module lsq_step_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;
  logic         adv;

  always_comb begin
    adv   = (cnt != {W{1'b1}});
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/lsq_rx_ovrd.sv
module lsq_rx_ovrd #(
  parameter int WIDTH = 16,
  parameter int BIT_A = 5,
  parameter int BIT_B = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] ovrd_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    if (g == BIT_A || g == BIT_B) begin : g_live
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
      end
      assign ovrd_o[g] = q;
    end else begin : g_tie
      assign ovrd_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/lsq_link_bringup.sv
module lsq_link_bringup
  import lsq_pkg::*;
#(
  parameter int LINK_TIMEOUT = 1000,
  parameter int POLL_RETRIES = 200,
  parameter int HOLD_CYCLES  = 1000,
  parameter int OVRD_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        max_gen_i,
  input  logic              chg_poll_en_i,
  input  logic              link_up_i,
  input  logic              spd_chg_pending_i,
  input  logic [3:0]        lnk_sta_speed_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [3:0]        cur_speed_o,
  output logic [3:0]        sup_speed_o,
  output logic              spd_chg_set_o,
  output logic              ltssm_en_o,
  output logic [OVRD_W-1:0] rx_ovrd_o
);

  localparam int LIM = max3(LINK_TIMEOUT, POLL_RETRIES, HOLD_CYCLES);
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] TO_LAST   = CW'(LINK_TIMEOUT - 1);
  localparam logic [CW-1:0] POLL_LAST = CW'(POLL_RETRIES - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

  seq_state_e st_q, st_d;
  logic [CW-1:0] cnt;
  logic          cnt_clr;
  logic          want_gen2;

  logic [3:0] sup_q, sup_d;
  logic       ltssm_q, ltssm_d;
  logic [3:0] cur_q, cur_d;
  logic       ovrd_set, ovrd_clr;

  assign want_gen2 = (max_gen_i >= 2'd2);

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_FORCE;
      ST_FORCE:  st_d = ST_TRAIN;
      ST_TRAIN: begin
        if (link_up_i)          st_d = want_gen2 ? ST_RAISE : ST_DONE;
        else if (cnt == TO_LAST) st_d = ST_PHYRST;
      end
      ST_RAISE:  st_d = ST_REQ;
      ST_REQ:    st_d = chg_poll_en_i ? ST_POLL : ST_RELINK;
      ST_POLL: begin
        if (!spd_chg_pending_i)    st_d = ST_RELINK;
        else if (cnt == POLL_LAST) st_d = ST_PHYRST;
      end
      ST_RELINK: begin
        if (link_up_i)           st_d = ST_DONE;
        else if (cnt == TO_LAST) st_d = ST_PHYRST;
      end
      ST_PHYRST: if (cnt == HOLD_LAST) st_d = ST_FAIL;
      ST_DONE:   st_d = ST_IDLE;
      ST_FAIL:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  assign cnt_clr = (st_d != st_q);

  // register next values
  always_comb begin
    sup_d   = sup_q;
    ltssm_d = ltssm_q;
    cur_d   = cur_q;
    if (cnt_clr) begin
      unique case (st_d)
        ST_FORCE: begin
          sup_d   = SPD_2G5;
          ltssm_d = 1'b0;
          cur_d   = 4'h0;
        end
        ST_TRAIN: ltssm_d = 1'b1;
        ST_RAISE: sup_d   = SPD_5G0;
        ST_DONE:  cur_d   = lnk_sta_speed_i;
        default: ;
      endcase
    end
  end

  assign ovrd_set = cnt_clr && (st_d == ST_PHYRST);
  assign ovrd_clr = cnt_clr && (st_q == ST_PHYRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sup_q   <= 4'h0;
      ltssm_q <= 1'b0;
      cur_q   <= 4'h0;
    end else begin
      st_q    <= st_d;
      sup_q   <= sup_d;
      ltssm_q <= ltssm_d;
      cur_q   <= cur_d;
    end
  end

  lsq_step_ctr #(.W(CW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .cnt   (cnt)
  );

  lsq_rx_ovrd #(
    .WIDTH (OVRD_W),
    .BIT_A (RX_DATA_OVRD_BIT),
    .BIT_B (RX_PLL_OVRD_BIT)
  ) u_ovrd (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ovrd_set),
    .clr_i  (ovrd_clr),
    .ovrd_o (rx_ovrd_o)
  );

  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = (st_q == ST_DONE);
  assign fail_o        = (st_q == ST_FAIL);
  assign spd_chg_set_o = (st_q == ST_REQ);
  assign sup_speed_o   = sup_q;
  assign ltssm_en_o    = ltssm_q;
  assign cur_speed_o   = cur_q;

endmodule

// File: rtl/lsq_link_bringup_chk.sv
module lsq_link_bringup_chk #(
  parameter int HOLD_CYCLES = 1000,
  parameter int OVRD_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        max_gen_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [3:0]        sup_speed_o,
  input logic              spd_chg_set_o,
  input logic              ltssm_en_o,
  input logic [OVRD_W-1:0] rx_ovrd_o
);

  localparam logic [OVRD_W-1:0] OVRD_MASK =
    OVRD_W'((1 << lsq_pkg::RX_DATA_OVRD_BIT) | (1 << lsq_pkg::RX_PLL_OVRD_BIT));

  int hold_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  hold_cnt <= 0;
    else if (rx_ovrd_o[lsq_pkg::RX_PLL_OVRD_BIT]) hold_cnt <= hold_cnt + 1;
    else                                         hold_cnt <= 0;
  end

  a_r2_train_at_gen1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ltssm_en_o) |-> (sup_speed_o == lsq_pkg::SPD_2G5));

  a_r4_req_at_gen2: assert property (@(posedge clk) disable iff (!rst_n)
    spd_chg_set_o |-> (sup_speed_o == lsq_pkg::SPD_5G0) && (max_gen_i >= 2'd2));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    spd_chg_set_o |=> !spd_chg_set_o);

  a_r8_ovrd_value: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovrd_o != '0) |-> (rx_ovrd_o == OVRD_MASK));

  a_r8_fail_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ovrd_o[lsq_pkg::RX_PLL_OVRD_BIT]) |-> fail_o);

  a_r8_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ovrd_o[lsq_pkg::RX_PLL_OVRD_BIT]) |-> (hold_cnt == HOLD_CYCLES));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  a_r9_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |=> !busy_o);

  a_r10_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && !fail_o) |=> busy_o);

endmodule

bind lsq_link_bringup lsq_link_bringup_chk #(
  .HOLD_CYCLES (HOLD_CYCLES),
  .OVRD_W      (OVRD_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .max_gen_i     (max_gen_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .fail_o        (fail_o),
  .sup_speed_o   (sup_speed_o),
  .spd_chg_set_o (spd_chg_set_o),
  .ltssm_en_o    (ltssm_en_o),
  .rx_ovrd_o     (rx_ovrd_o)
);

// File: tb/sim_lsq_link_bringup.sv
module sim_lsq_link_bringup;

  localparam int CLK_PERIOD = 10;
  localparam int TO   = 40;
  localparam int RET  = 12;
  localparam int HOLD = 8;

  typedef struct packed {
    logic [1:0] gen;
    logic       poll;
    logic [7:0] up_d;     // cycles of training before link-up, 255 = never
    logic [7:0] clr_d;    // cycles before request bit clears, 255 = never
    logic       relink;   // link survives speed change
    logic       exp_done;
    logic [3:0] exp_spd;
    logic       exp_chg;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b1, 8'd3,   8'd255, 1'b1, 1'b1, 4'd1, 1'b0, 4'd4}, // R4 gen1 only
    '{2'd2, 1'b1, 8'd5,   8'd4,   1'b1, 1'b1, 4'd2, 1'b1, 4'd5}, // R5 poll clears
    '{2'd2, 1'b0, 8'd2,   8'd255, 1'b1, 1'b1, 4'd2, 1'b1, 4'd6}, // R6 stuck bit ok
    '{2'd2, 1'b1, 8'd2,   8'd255, 1'b1, 1'b0, 4'd0, 1'b1, 4'd5}, // R5 stuck bit fails
    '{2'd1, 1'b0, 8'd39,  8'd255, 1'b1, 1'b1, 4'd1, 1'b0, 4'd3}, // R3 last cycle
    '{2'd1, 1'b0, 8'd40,  8'd255, 1'b1, 1'b0, 4'd0, 1'b0, 4'd3}, // R3 timeout
    '{2'd2, 1'b1, 8'd0,   8'd11,  1'b1, 1'b1, 4'd2, 1'b1, 4'd5}, // R5 last retry
    '{2'd2, 1'b1, 8'd0,   8'd12,  1'b1, 1'b0, 4'd0, 1'b1, 4'd5}, // R5 exhausted
    '{2'd2, 1'b0, 8'd4,   8'd1,   1'b0, 1'b0, 4'd0, 1'b1, 4'd7}, // R7 relink lost
    '{2'd3, 1'b1, 8'd1,   8'd2,   1'b1, 1'b1, 4'd2, 1'b1, 4'd4}, // R4 gen3 cap
    '{2'd0, 1'b1, 8'd1,   8'd255, 1'b1, 1'b1, 4'd1, 1'b0, 4'd4}  // R4 gen0
  };

  logic clk, rst_n, start;
  logic [1:0] max_gen;
  logic poll_en, link_up, pend;
  logic [3:0] lnk_spd;
  logic busy, done, fail, chg_set, ltssm;
  logic [3:0] cur_spd, sup_spd;
  logic [15:0] ovrd;

  // controller model configuration and state
  logic [7:0] cfg_up, cfg_clr;
  logic       cfg_relink;
  logic [7:0] up_cnt, pc;
  logic       dropped, chg_seen;

  int n_chk, n_bad;

  lsq_link_bringup #(
    .LINK_TIMEOUT (TO),
    .POLL_RETRIES (RET),
    .HOLD_CYCLES  (HOLD),
    .OVRD_W       (16)
  ) u0 (
    .clk               (clk),
    .rst_n             (rst_n),
    .start_i           (start),
    .max_gen_i         (max_gen),
    .chg_poll_en_i     (poll_en),
    .link_up_i         (link_up),
    .spd_chg_pending_i (pend),
    .lnk_sta_speed_i   (lnk_spd),
    .busy_o            (busy),
    .done_o            (done),
    .fail_o            (fail),
    .cur_speed_o       (cur_spd),
    .sup_speed_o       (sup_spd),
    .spd_chg_set_o     (chg_set),
    .ltssm_en_o        (ltssm),
    .rx_ovrd_o         (ovrd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  assign link_up = ltssm && !dropped && (cfg_up != 8'd255) && (up_cnt >= cfg_up);
  assign lnk_spd = !link_up ? 4'd0 : ((chg_seen && sup_spd == 4'h2) ? 4'd2 : 4'd1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt <= 8'd0; pc <= 8'd0; pend <= 1'b0; dropped <= 1'b0; chg_seen <= 1'b0;
    end else if (!ltssm) begin
      up_cnt <= 8'd0; pend <= 1'b0; dropped <= 1'b0; chg_seen <= 1'b0;
    end else begin
      if (up_cnt != 8'd255) up_cnt <= up_cnt + 8'd1;
      if (chg_set) begin
        pend <= 1'b1; pc <= 8'd0; chg_seen <= 1'b1;
        if (!cfg_relink) dropped <= 1'b1;
      end else if (pend && cfg_clr != 8'd255) begin
        if (pc + 8'd1 == cfg_clr) pend <= 1'b0;
        else                      pc <= pc + 8'd1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // run results
  int r_done, r_fail, r_chg, r_ovrd_hi, r_ovrd_bad, r_rise_bad, r_chg_bad;
  int r_falls, r_train, r_busy_after, r_pulse_after, r_hung;
  logic [3:0] r_spd;

  task automatic run(input vec_t v, input int poke_at);
    logic prev_l, rise_seen;
    max_gen = v.gen; poll_en = v.poll; cfg_up = v.up_d; cfg_clr = v.clr_d;
    cfg_relink = v.relink;
    r_done = 0; r_fail = 0; r_chg = 0; r_ovrd_hi = 0; r_ovrd_bad = 0;
    r_rise_bad = 0; r_chg_bad = 0; r_falls = 0; r_train = 0; r_hung = 1;
    r_spd = 4'hF; rise_seen = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    prev_l = ltssm;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      start = (c == poke_at || c == poke_at + 1);
      if (ltssm && !prev_l) begin
        rise_seen = 1'b1;
        if (sup_spd != 4'h1) r_rise_bad++;
      end
      if (!ltssm && prev_l && rise_seen) r_falls++;
      if (chg_set) begin
        r_chg++;
        if (sup_spd != 4'h2) r_chg_bad++;
      end
      if (ovrd != 16'h0) begin
        r_ovrd_hi++;
        if (ovrd != 16'h0028) r_ovrd_bad++;
      end else if (ltssm && rise_seen && r_chg == 0 && !done && !fail) r_train++;
      if (done) begin r_done++; r_spd = cur_spd; end
      if (fail) begin r_fail++; r_spd = cur_spd; end
      prev_l = ltssm;
      if (done || fail) begin r_hung = 0; break; end
    end
    start = 1'b0;
    @(negedge clk);
    r_busy_after  = busy;
    r_pulse_after = done | fail;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; start = 1'b0; max_gen = 2'd0; poll_en = 1'b0;
    cfg_up = 8'd255; cfg_clr = 8'd255; cfg_relink = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ltssm in reset", ltssm, 0);
    chk("R1 ovrd in reset", ovrd, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done|fail", done | fail, 0);
    chk("R1 sup speed", sup_spd, 0);
    chk("R1 cur speed", cur_spd, 0);
    chk("R1 ltssm", ltssm, 0);
    chk("R1 chg set", chg_set, 0);
    chk("R1 ovrd", ovrd, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VECS[i].req, i);
      run(VECS[i], -10);
      chk({t, " hung"}, r_hung, 0);
      chk({t, " R9 done"}, r_done, VECS[i].exp_done);
      chk({t, " R9 fail"}, r_fail, !VECS[i].exp_done);
      chk({t, " R9 speed"}, r_spd, VECS[i].exp_spd);
      chk({t, " R9 idle after"}, r_busy_after, 0);
      chk({t, " R9 single pulse"}, r_pulse_after, 0);
      chk({t, " R4 chg pulses"}, r_chg, VECS[i].exp_chg);
      chk({t, " R4 field at chg"}, r_chg_bad, 0);
      chk({t, " R2 field at rise"}, r_rise_bad, 0);
      chk({t, " R8 ovrd cycles"}, r_ovrd_hi, VECS[i].exp_done ? 0 : HOLD);
      chk({t, " R8 ovrd value"}, r_ovrd_bad, 0);
    end

    // R3: training window length when link never comes up
    run(VECS[5], -10);
    chk("R3 train cycles before override", r_train, TO);

    // R10: second start mid-run ignored
    run(VECS[1], 3);
    chk("R10 ltssm falls", r_falls, 0);
    chk("R10 done count", r_done, 1);
    chk("R10 speed", r_spd, 2);
    chk("R10 idle after", r_busy_after, 0);
    run(VECS[3], 20);
    chk("R10 fail count", r_fail, 1);
    chk("R10 ltssm falls in fail run", r_falls, 0);

    // R6: disabled poll with a bit that never clears still finishes at 5 GT/s
    run(VECS[2], -10);
    chk("R6 done with stuck bit", r_done, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule